// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break-Field Generator

This block sends 8-bit characters on a single serial line and can also send a synchronization break of selectable length, as used to open a frame on single-wire automotive buses. All bit timing comes from an externally supplied bit-rate tick. The tick is one clock cycle wide and arrives once per bit period. Software-side logic writes a byte through a one-cycle write strobe, or sets the break trigger with a one-cycle strobe. The block then frames the request on the line and raises a one-cycle interrupt pulse at the moment it accepts the request.

A break drives the line low for 13 to 20 bit periods, set by a 3-bit length code. One high stop period follows. The trigger bit is visible as an output and clears itself when the break is over, after which ordinary characters can be sent again. Transmission runs only while both the power enable and the transmit enable are high. Dropping either one stops any frame at once and parks the line high.

Top module: `brk_uart_tx`

## Requirements
- R1: After reset, `txd` is 1 and `busy`, `tx_irq` and `brk_pend` are 0.
- R2: While `pwr_en` or `tx_en` is 0, write strobes and break strobes are ignored: `busy` and `tx_irq` stay 0 and `txd` stays 1.
- R3: An accepted write sends a frame that begins at the first `bit_tick` after acceptance. The frame is a start bit of 0, then the 8 data bits least-significant bit first, then a stop bit of 1, each lasting one tick period. `busy` clears at the 11th tick after acceptance.
- R4: An accepted break drives `txd` to 0 for exactly 13 + `brk_len_sel` tick periods, starting at the first tick after acceptance. Code 0 gives 13 periods and code 7 gives 20.
- R5: The low part of a break is followed by exactly one high tick period, and `busy` clears at the tick that ends it.
- R6: `tx_irq` is a single-cycle pulse in the cycle after a character or break is accepted, and is 0 at all other times.
- R7: `brk_pend` rises on the same clock edge that accepts a break, and falls on the same edge that clears `busy` at the end of the break.
- R8: While `busy` is 1, break strobes and write strobes are ignored: the frame on `txd` is unchanged and no `tx_irq` pulse is produced.
- R9: If a break strobe and a write strobe arrive in the same idle cycle, the break is sent and the byte is discarded.
- R10: When `pwr_en` or `tx_en` is low at a clock edge, then after that edge `txd` is 1 and `busy` and `brk_pend` are 0.
- R11: `txd` changes only at a clock edge where `bit_tick` is 1, or where an enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| pwr_en | input | 1 | Power enable |
| tx_en | input | 1 | Transmit enable |
| brk_len_sel | input | 3 | Break length code; length = 13 + code |
| brk_go | input | 1 | One-cycle strobe that sets the break trigger |
| wr_valid | input | 1 | One-cycle write strobe for a data byte |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial line, idles high |
| tx_irq | output | 1 | One-cycle pulse on acceptance of a character or break |
| busy | output | 1 | A character or break is in progress |
| brk_pend | output | 1 | Break trigger bit; clears itself when the break ends |

## Verification
A strobe applied before a clock edge shows its `tx_irq`, `busy` and `brk_pend` response one cycle later. The bench drives inputs on the falling edge and checks these outputs on the next falling edge. The line level for tick k of a frame is due one cycle after the k-th tick edge that follows acceptance. The bench waits for each tick edge, samples on the following falling edge, and compares against a level computed from the byte or the length code. Between ticks it confirms that the line holds still. An abort is checked on the falling edge right after the first edge that sees the enable low.

// File: rtl/brk_uart_pkg.sv
package brk_uart_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_BRK,
        ST_BSTOP
    } tx_state_e;

endpackage

// File: rtl/brk_uart_len.sv
module brk_uart_len #(
    parameter int SEL_W    = 3,
    parameter int BRK_BASE = 13,
    parameter int CNT_W    = 5
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] last_cnt
);
    // Count loaded at acceptance: number of low periods minus one.
    localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(BRK_BASE - 1);

    always_comb begin
        last_cnt = BASE_M1 + CNT_W'(sel);
    end
endmodule

// File: rtl/brk_uart_arb.sv
module brk_uart_arb (
    input  logic en,
    input  logic idle,
    input  logic brk_go,
    input  logic wr_valid,
    output logic start_brk,
    output logic start_chr
);
    // Requests are taken only when idle and enabled; a break outranks a write.
    always_comb begin
        start_brk = en && idle && brk_go;
        start_chr = en && idle && wr_valid && !brk_go;
    end
endmodule

// File: rtl/brk_uart_tx.sv
module brk_uart_tx #(
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 3,
    parameter int BRK_BASE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              pwr_en,
    input  logic              tx_en,
    input  logic [SEL_W-1:0]  brk_len_sel,
    input  logic              brk_go,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_irq,
    output logic              busy,
    output logic              brk_pend
);
    import brk_uart_pkg::*;

    localparam int LEN_MAX = BRK_BASE + (1 << SEL_W) - 1;
    localparam int CNT_TOP = (LEN_MAX > DATA_W) ? LEN_MAX : DATA_W;
    localparam int CNT_W   = $clog2(CNT_TOP + 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    typedef struct packed {
        tx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              txd;
        logic              irq;
        logic              trig;
    } tx_regs_t;

    tx_regs_t q, d;

    logic             en;
    logic             start_brk;
    logic             start_chr;
    logic [CNT_W-1:0] brk_last;

    assign en = pwr_en && tx_en;

    brk_uart_arb u_arb (
        .en        (en),
        .idle      (q.state == ST_IDLE),
        .brk_go    (brk_go),
        .wr_valid  (wr_valid),
        .start_brk (start_brk),
        .start_chr (start_chr)
    );

    brk_uart_len #(
        .SEL_W    (SEL_W),
        .BRK_BASE (BRK_BASE),
        .CNT_W    (CNT_W)
    ) u_len (
        .sel      (brk_len_sel),
        .last_cnt (brk_last)
    );

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (!en) begin
            d.state = ST_IDLE;
            d.txd   = 1'b1;
            d.trig  = 1'b0;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    if (start_brk) begin
                        d.state = ST_ALIGN;
                        d.trig  = 1'b1;
                        d.irq   = 1'b1;
                        d.cnt   = brk_last;
                    end else if (start_chr) begin
                        d.state = ST_ALIGN;
                        d.irq   = 1'b1;
                        d.sh    = wr_data;
                    end
                end
                ST_ALIGN: begin
                    if (bit_tick) begin
                        d.txd   = 1'b0;
                        d.state = q.trig ? ST_BRK : ST_START;
                    end
                end
                ST_START: begin
                    if (bit_tick) begin
                        d.txd   = q.sh[0];
                        d.sh    = q.sh >> 1;
                        d.cnt   = DATA_LAST;
                        d.state = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (bit_tick) begin
                        if (q.cnt == '0) begin
                            d.txd   = 1'b1;
                            d.state = ST_STOP;
                        end else begin
                            d.txd = q.sh[0];
                            d.sh  = q.sh >> 1;
                            d.cnt = q.cnt - CNT_ONE;
                        end
                    end
                end
                ST_STOP: begin
                    if (bit_tick) begin
                        d.state = ST_IDLE;
                    end
                end
                ST_BRK: begin
                    if (bit_tick) begin
                        if (q.cnt == '0) begin
                            d.txd   = 1'b1;
                            d.state = ST_BSTOP;
                        end else begin
                            d.cnt = q.cnt - CNT_ONE;
                        end
                    end
                end
                ST_BSTOP: begin
                    if (bit_tick) begin
                        d.state = ST_IDLE;
                        d.trig  = 1'b0;
                    end
                end
                default: begin
                    d.state = ST_IDLE;
                    d.txd   = 1'b1;
                    d.trig  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.cnt   <= '0;
            q.sh    <= '0;
            q.txd   <= 1'b1;
            q.irq   <= 1'b0;
            q.trig  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign txd      = q.txd;
    assign tx_irq   = q.irq;
    assign busy     = (q.state != ST_IDLE);
    assign brk_pend = q.trig;

endmodule

// File: rtl/brk_uart_tx_chk.sv
module brk_uart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic pwr_en,
    input logic tx_en,
    input logic brk_go,
    input logic wr_valid,
    input logic txd,
    input logic tx_irq,
    input logic busy,
    input logic brk_pend
);
    logic en_c;
    assign en_c = pwr_en && tx_en;

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_c |=> (txd && !busy && !brk_pend));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    assert_irq_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (busy && !$past(busy)));

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && en_c && (brk_go || wr_valid)) |=> !tx_irq);

    assert_pend_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pend |-> busy);

    assert_pend_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_pend) |-> !$past(busy));

    assert_line_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> ($past(bit_tick) || !$past(en_c)));

endmodule

bind brk_uart_tx brk_uart_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .pwr_en   (pwr_en),
    .tx_en    (tx_en),
    .brk_go   (brk_go),
    .wr_valid (wr_valid),
    .txd      (txd),
    .tx_irq   (tx_irq),
    .busy     (busy),
    .brk_pend (brk_pend)
);

// File: tb/brk_uart_tx_tb.sv
module brk_uart_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       pwr_en = 1'b1;
    logic       tx_en = 1'b1;
    logic [2:0] brk_len_sel = '0;
    logic       brk_go = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd, tx_irq, busy, brk_pend;

    int  n_run = 0;
    int  n_fail = 0;
    bit  glitch = 1'b0;

    always #2.5 clk = ~clk;

    brk_uart_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .pwr_en(pwr_en),
        .tx_en(tx_en), .brk_len_sel(brk_len_sel), .brk_go(brk_go),
        .wr_valid(wr_valid), .wr_data(wr_data), .txd(txd),
        .tx_irq(tx_irq), .busy(busy), .brk_pend(brk_pend)
    );

    // Tick every 4 cycles, driven on the falling edge.
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % 4;
            bit_tick = (div == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_chr(input logic [7:0] dv, input int k);
        if (k == 1) return 1'b0;
        if (k <= 9) return dv[k-2];
        return 1'b1;
    endfunction

    function automatic bit exp_brk(input int sel, input int k);
        return (k <= 13 + sel) ? 1'b0 : 1'b1;
    endfunction

    task automatic wait_tick();
        logic prev;
        prev = txd;
        forever begin
            @(posedge clk);
            if (bit_tick) break;
            @(negedge clk);
            if (txd !== prev) glitch = 1'b1;
        end
        @(negedge clk);
    endtask

    // Called on a falling edge; drives strobes for one cycle.
    task automatic start_req(input bit do_brk, input bit do_wr,
                             input logic [7:0] dv, input int sel);
        brk_len_sel = 3'(sel);
        wr_data     = dv;
        brk_go      = do_brk;
        wr_valid    = do_wr;
        @(negedge clk);
        brk_go   = 1'b0;
        wr_valid = 1'b0;
        chk(tx_irq == 1'b1, "R6", "irq after accept", int'(tx_irq), 1);
        chk(busy == 1'b1, "R3", "busy after accept", int'(busy), 1);
        chk(brk_pend == do_brk, "R7", "trigger at accept", int'(brk_pend), int'(do_brk));
        chk(txd == 1'b1, "R3", "line high before first tick", int'(txd), 1);
    endtask

    task automatic follow(input bit is_brk, input logic [7:0] dv, input int sel,
                          input int intrude_at, input bit intrude_brk);
        int  n;
        bit  e;
        n = is_brk ? (15 + sel) : 11;
        glitch = 1'b0;
        for (int k = 1; k <= n; k++) begin
            wait_tick();
            e = is_brk ? exp_brk(sel, k) : exp_chr(dv, k);
            if (is_brk) chk(txd == e, "R4", "break line level", int'(txd), int'(e));
            else        chk(txd == e, "R3", "char line level", int'(txd), int'(e));
            if (k < n) begin
                chk(busy == 1'b1, is_brk ? "R5" : "R3", "busy mid frame", int'(busy), 1);
            end else begin
                chk(busy == 1'b0, is_brk ? "R5" : "R3", "busy at end", int'(busy), 0);
                chk(brk_pend == 1'b0, "R7", "trigger self clear", int'(brk_pend), 0);
            end
            if (k == intrude_at && k < n) begin
                brk_go   = intrude_brk;
                wr_valid = !intrude_brk;
                wr_data  = ~dv;
                @(negedge clk);
                brk_go   = 1'b0;
                wr_valid = 1'b0;
                chk(tx_irq == 1'b0, "R8", "no irq while busy", int'(tx_irq), 0);
                chk(brk_pend == is_brk, "R8", "trigger unchanged while busy",
                    int'(brk_pend), int'(is_brk));
            end
        end
        chk(glitch == 1'b0, "R11", "line moved between ticks", int'(glitch), 0);
        @(negedge clk);
        chk(tx_irq == 1'b0, "R6", "irq quiet after frame", int'(tx_irq), 0);
    endtask

    task automatic abort_case(input bit is_brk, input bit drop_pwr);
        start_req(is_brk, !is_brk, 8'h00, 2);
        wait_tick();
        wait_tick();
        if (drop_pwr) pwr_en = 1'b0; else tx_en = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R10", "line high after abort", int'(txd), 1);
        chk(busy == 1'b0, "R10", "idle after abort", int'(busy), 0);
        chk(brk_pend == 1'b0, "R10", "trigger cleared by abort", int'(brk_pend), 0);
        pwr_en = 1'b1;
        tx_en  = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        chk(txd == 1'b1 && busy == 1'b0 && tx_irq == 1'b0 && brk_pend == 1'b0,
            "R1", "reset outputs", {28'd0, txd, busy, tx_irq, brk_pend}, 8);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disabled, strobes ignored
        pwr_en = 1'b0;
        brk_go = 1'b1; wr_valid = 1'b1; wr_data = 8'h5A;
        @(negedge clk);
        brk_go = 1'b0; wr_valid = 1'b0;
        chk(busy == 1'b0 && tx_irq == 1'b0, "R2", "power off ignores strobes",
            int'(busy) + int'(tx_irq), 0);
        pwr_en = 1'b1; tx_en = 1'b0;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy == 1'b0 && txd == 1'b1, "R2", "tx off ignores write",
            int'(busy) + 2 * int'(!txd), 0);
        tx_en = 1'b1;
        @(negedge clk);

        // Directed corner cases
        start_req(1'b0, 1'b1, 8'hA5, 0);  follow(1'b0, 8'hA5, 0, 0, 1'b0);
        start_req(1'b0, 1'b1, 8'h01, 0);  follow(1'b0, 8'h01, 0, 0, 1'b0);
        start_req(1'b1, 1'b0, 8'h00, 0);  follow(1'b1, 8'h00, 0, 0, 1'b0);
        start_req(1'b1, 1'b0, 8'h00, 7);  follow(1'b1, 8'h00, 7, 0, 1'b0);
        // R9: break wins over write in the same cycle
        start_req(1'b1, 1'b1, 8'h3C, 4);  follow(1'b1, 8'h00, 4, 0, 1'b0);
        repeat (12) @(negedge clk);
        chk(busy == 1'b0 && txd == 1'b1, "R9", "write discarded after break",
            int'(busy), 0);
        // R8: intrusions while busy
        start_req(1'b0, 1'b1, 8'hC3, 0);  follow(1'b0, 8'hC3, 0, 4, 1'b1);
        start_req(1'b1, 1'b0, 8'h00, 3);  follow(1'b1, 8'h00, 3, 6, 1'b0);
        // R10: aborts
        abort_case(1'b0, 1'b0);
        abort_case(1'b1, 1'b1);

        // Random mix
        for (int i = 0; i < 24; i++) begin
            bit         rb;
            logic [7:0] rd;
            int         rs;
            int         ri;
            rb = $urandom % 2;
            rd = 8'($urandom);
            rs = $urandom % 8;
            ri = ($urandom % 3 == 0) ? 1 + $urandom % 9 : 0;
            repeat ($urandom % 5) @(negedge clk);
            start_req(rb, !rb, rd, rs);
            follow(rb, rd, rs, ri, $urandom % 2);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule